// File: doc/BRIEF.md
# Cache Range Maintenance Splitter

This block takes one cache maintenance request and turns it into a series of commands that a cache controller port can execute. A request carries a byte start address, an exclusive byte end address and an operation: invalidate, clean, flush, or a reserved no-op code. The block aligns the request to cache lines. On invalidate it gives any partly covered edge line its own single-line clean-and-invalidate, so that bytes outside the request are not lost. It then cuts the line-aligned body into range commands. Each range command has an inclusive first-line and last-line address. No range command covers more than a fixed number of bytes, and none crosses a page.

Commands leave through a valid/ready handshake. A one-cycle `done` pulse follows the acceptance of the last command and marks the point where the caller may treat the maintenance as ordered. A write-through override, sampled together with the request, suppresses the clean work, which cannot be needed when the cache never holds dirty data. Requests are taken only while the block is idle. Defaults: 32-byte lines, 1024-byte maximum span, 4096-byte pages, 32-bit addresses.

Top module: `cache_range_splitter`

## Requirements
- R1: Every command address is line aligned (its low log2(LINE_BYTES) bits are zero). A range command's end is the address of its last line, which is the exclusive chunk end minus one line.
- R2: A range command spans at most MAX_SPAN bytes, so its end minus its start is at most MAX_SPAN−LINE_BYTES. The next chunk starts one line after the previous end.
- R3: A range command never crosses a page: its start and end agree in every bit from log2(PAGE_BYTES) upward.
- R4: For invalidate (op code 0) with a misaligned start, the first command is a single-line clean-and-invalidate (kind 0, start equal to end) at the start rounded down. The working start then moves to the next line boundary.
- R5: For invalidate, if the rounded-up start is still below the end and the end is misaligned, a kind-0 command at the end rounded down follows. The working end then rounds down.
- R6: For clean (op 1) and flush (op 2), the start rounds down and the end rounds up to a line boundary before chunking. Invalidate range commands use kind 2 and clean range commands use kind 1.
- R7: For flush, each chunk issues a clean range (kind 1) and then an invalidate range (kind 2) with identical bounds.
- R8: When the write-through override is high at request acceptance, clean requests issue no commands and flush requests issue only their kind-2 range commands.
- R9: A request whose aligned start is not below its aligned end issues no range commands. The reserved op code 3 issues no commands at all. Both still end with a `done` pulse.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command stays unchanged. `done` is high for exactly one cycle after the last acceptance, and the block returns to accepting requests.
- R11: After reset, `req_ready` is 1 and `cmd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 no-op |
| req_start | input | AW | First byte address |
| req_end | input | AW | Exclusive end byte address |
| wt_override | input | 1 | Cache runs write-through; sampled with the request |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Cache port accepts the command |
| cmd_kind | output | 2 | 0 single-line clean+invalidate, 1 clean range, 2 invalidate range |
| cmd_start | output | AW | Inclusive first line address |
| cmd_end | output | AW | Inclusive last line address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case is a range where all three chunk limits act in one request: a chunk cut short by the page edge, then full-span chunks, then a short tail, all while the cache port stalls unpredictably between the clean and invalidate halves of a flush. The stimulus reaches it with long clean and flush requests that start a few lines below a page edge. It drives `cmd_ready` from a shift-register pattern, so commands sit stalled for varying numbers of cycles. Invalidate requests whose edges fall inside one line cover the cases where the tail line is or is not issued.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_NONE  = 2'd3
  } maint_op_e;

  typedef enum logic [1:0] {
    CMD_LINE_CI   = 2'd0,
    CMD_CLEAN_RNG = 2'd1,
    CMD_INV_RNG   = 2'd2,
    CMD_RSVD      = 2'd3
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_HEAD,
    ST_TAIL,
    ST_CLEAN,
    ST_INV,
    ST_DONE
  } split_st_e;
endpackage

// File: rtl/crs_edge.sv
module crs_edge
  import crs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input  maint_op_e         op,
  input  logic [AW-1:0]     start_a,
  input  logic [AW-1:0]     end_a,
  output logic [AW-1:0]     cur0,
  output logic [AW-1:0]     lim0,
  output logic              head_pend,
  output logic [AW-1:0]     head_addr,
  output logic              tail_pend,
  output logic [AW-1:0]     tail_addr
);
  localparam int LB = $clog2(LINE_BYTES);

  function automatic logic [AW-1:0] line_dn(input logic [AW-1:0] a);
    return {a[AW-1:LB], {LB{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] line_up(input logic [AW-1:0] a);
    return line_dn(a + AW'(LINE_BYTES - 1));
  endfunction

  logic start_mis, end_mis;
  logic [AW-1:0] start_fwd;

  assign start_mis = |start_a[LB-1:0];
  assign end_mis   = |end_a[LB-1:0];
  assign start_fwd = start_mis ? line_dn(start_a) + AW'(LINE_BYTES) : start_a;

  always_comb begin
    head_pend = 1'b0;
    tail_pend = 1'b0;
    head_addr = line_dn(start_a);
    tail_addr = line_dn(end_a);
    if (op == OP_INV) begin
      head_pend = start_mis;
      cur0      = start_fwd;
      tail_pend = (start_fwd < end_a) && end_mis;
      lim0      = line_dn(end_a);
    end else begin
      cur0 = line_dn(start_a);
      lim0 = line_up(end_a);
    end
  end
endmodule

// File: rtl/crs_chunk.sv
module crs_chunk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_SPAN   = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] lim,
  output logic          more,
  output logic [AW-1:0] chunk_end,
  output logic [AW-1:0] rng_last
);
  localparam logic [AW:0] SPAN_W  = (AW+1)'(MAX_SPAN);
  localparam logic [AW:0] PG_MASK = (AW+1)'(PAGE_BYTES - 1);

  function automatic logic [AW:0] clamp3(input logic [AW:0] c,
                                         input logic [AW:0] l,
                                         input logic [AW:0] p);
    logic [AW:0] r;
    r = c;
    if (r > l) r = l;
    if (r > p) r = p;
    return r;
  endfunction

  logic [AW:0] cur_w, by_span, by_page, ce_w;

  assign cur_w   = {1'b0, cur};
  assign by_span = cur_w + SPAN_W;
  assign by_page = (cur_w | PG_MASK) + (AW+1)'(1);
  assign ce_w    = clamp3(by_span, {1'b0, lim}, by_page);
  assign more      = cur < lim;
  assign chunk_end = ce_w[AW-1:0];
  assign rng_last  = chunk_end - AW'(LINE_BYTES);

  always_comb begin
    if (more) begin
      a_chunk_progress_r2: assert (ce_w > cur_w && (ce_w - cur_w) <= SPAN_W)
        else $error("chunk does not advance within span");
    end
  end
endmodule

// File: rtl/cache_range_splitter.sv
module cache_range_splitter
  import crs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_SPAN   = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_end,
  input  logic          wt_override,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_start,
  output logic [AW-1:0] cmd_end,
  output logic          done
);
  localparam int LB  = $clog2(LINE_BYTES);
  localparam int PGB = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] MAX_DELTA = AW'(MAX_SPAN - LINE_BYTES);

  split_st_e st_q, st_d;
  maint_op_e op_q;
  logic      wt_q;
  logic [AW-1:0] cur_q, lim_q, head_addr_q, tail_addr_q;
  logic head_pend_q, tail_pend_q;

  logic [AW-1:0] e_cur0, e_lim0, e_head, e_tail;
  logic e_head_pend, e_tail_pend;
  logic c_more;
  logic [AW-1:0] c_end, c_last;

  logic req_fire, cmd_fire, want_clean, want_inv;
  cmd_kind_e kind;

  crs_edge #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_edge (
    .op        (maint_op_e'(req_op)),
    .start_a   (req_start),
    .end_a     (req_end),
    .cur0      (e_cur0),
    .lim0      (e_lim0),
    .head_pend (e_head_pend),
    .head_addr (e_head),
    .tail_pend (e_tail_pend),
    .tail_addr (e_tail)
  );

  crs_chunk #(.AW(AW), .LINE_BYTES(LINE_BYTES), .MAX_SPAN(MAX_SPAN),
              .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .cur       (cur_q),
    .lim       (lim_q),
    .more      (c_more),
    .chunk_end (c_end),
    .rng_last  (c_last)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign cmd_valid = (st_q == ST_HEAD) || (st_q == ST_TAIL) ||
                     (st_q == ST_CLEAN) || (st_q == ST_INV);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign done      = (st_q == ST_DONE);

  // Which range work a chunk needs, given op and write-through override.
  assign want_clean = !wt_q && (op_q == OP_CLEAN || op_q == OP_FLUSH);
  assign want_inv   = (op_q == OP_INV) || (op_q == OP_FLUSH);

  always_comb begin
    case (st_q)
      ST_HEAD, ST_TAIL: kind = CMD_LINE_CI;
      ST_CLEAN:         kind = CMD_CLEAN_RNG;
      ST_INV:           kind = CMD_INV_RNG;
      default:          kind = CMD_RSVD;
    endcase
  end
  assign cmd_kind = kind;

  always_comb begin
    case (st_q)
      ST_HEAD: begin cmd_start = head_addr_q; cmd_end = head_addr_q; end
      ST_TAIL: begin cmd_start = tail_addr_q; cmd_end = tail_addr_q; end
      default: begin cmd_start = cur_q;       cmd_end = c_last;      end
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (req_fire) st_d = ST_PICK;
      ST_PICK: begin
        if (head_pend_q)                        st_d = ST_HEAD;
        else if (tail_pend_q)                   st_d = ST_TAIL;
        else if (c_more && want_clean)          st_d = ST_CLEAN;
        else if (c_more && want_inv)            st_d = ST_INV;
        else                                    st_d = ST_DONE;
      end
      ST_HEAD, ST_TAIL: if (cmd_fire) st_d = ST_PICK;
      ST_CLEAN: if (cmd_fire) st_d = (op_q == OP_FLUSH) ? ST_INV : ST_PICK;
      ST_INV:   if (cmd_fire) st_d = ST_PICK;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_NONE;
      wt_q        <= 1'b0;
      cur_q       <= '0;
      lim_q       <= '0;
      head_pend_q <= 1'b0;
      tail_pend_q <= 1'b0;
      head_addr_q <= '0;
      tail_addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (req_fire) begin
        op_q        <= maint_op_e'(req_op);
        wt_q        <= wt_override;
        cur_q       <= e_cur0;
        lim_q       <= e_lim0;
        head_pend_q <= e_head_pend;
        tail_pend_q <= e_tail_pend;
        head_addr_q <= e_head;
        tail_addr_q <= e_tail;
      end else if (cmd_fire) begin
        if (st_q == ST_HEAD) head_pend_q <= 1'b0;
        if (st_q == ST_TAIL) tail_pend_q <= 1'b0;
        if (st_q == ST_INV || (st_q == ST_CLEAN && op_q != OP_FLUSH))
          cur_q <= c_end;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_start) &&
                                $stable(cmd_end) && $stable(cmd_kind))
    else $error("stalled command changed");

  p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_start[LB-1:0] == '0) && (cmd_end[LB-1:0] == '0))
    else $error("unaligned command address");

  p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && kind != CMD_LINE_CI |-> cmd_start[AW-1:PGB] == cmd_end[AW-1:PGB])
    else $error("range crosses a page");

  p_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && kind != CMD_LINE_CI |->
      cmd_end >= cmd_start && (cmd_end - cmd_start) <= MAX_DELTA)
    else $error("range exceeds span");

  p_line_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && kind == CMD_LINE_CI |-> cmd_start == cmd_end)
    else $error("single-line op with two addresses");

  p_wt_noclean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wt_q |-> kind != CMD_CLEAN_RNG)
    else $error("clean issued under write-through override");

  p_flush_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && kind == CMD_CLEAN_RNG && op_q == OP_FLUSH |=>
      cmd_valid && kind == CMD_INV_RNG &&
      cmd_start == $past(cmd_start) && cmd_end == $past(cmd_end))
    else $error("flush clean not followed by matching invalidate");

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready)
    else $error("done longer than one cycle");

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !done)
    else $error("activity while idle");
endmodule

// File: tb/tb_cache_range_splitter.sv
module tb_cache_range_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam longint LINE = 32;
  localparam longint SPAN = 1024;
  localparam longint PAGE = 4096;

  typedef struct packed {
    logic [1:0]    k;
    logic [AW-1:0] s;
    logic [AW-1:0] e;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_end = '0;
  logic wt_override = 1'b0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [1:0] cmd_kind;
  logic [AW-1:0] cmd_start, cmd_end;
  logic done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  exp_t q[$];
  string cur_tag = "R11";
  bit stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 1'b0;
  logic [AW-1:0] ps_s, ps_e;
  logic [1:0] ps_k;

  cache_range_splitter #(.AW(AW)) dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_start, .req_end,
    .wt_override, .cmd_valid, .cmd_ready, .cmd_kind, .cmd_start, .cmd_end, .done
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: chooses ready, then compares any command that will be taken.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (prev_stall) begin
        check(cmd_valid && cmd_start == ps_s && cmd_end == ps_e && cmd_kind == ps_k,
              "R10", "stalled command stable", longint'(cmd_start), longint'(ps_s));
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = stall_mode ? (lfsr[0] & lfsr[5]) : 1'b1;
      if (cmd_valid && cmd_ready) begin
        if (q.size() == 0) begin
          check(1'b0, cur_tag, "unexpected command", longint'(cmd_start), 0);
        end else begin
          exp_t x;
          x = q.pop_front();
          check(cmd_kind == x.k, cur_tag, "kind", longint'(cmd_kind), longint'(x.k));
          check(cmd_start == x.s, cur_tag, "start", longint'(cmd_start), longint'(x.s));
          check(cmd_end == x.e, cur_tag, "end", longint'(cmd_end), longint'(x.e));
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      ps_s = cmd_start; ps_e = cmd_end; ps_k = cmd_kind;
    end
  end

  // Expected sequence from the requirements.
  task automatic expect_cmds(input int op, input longint s, input longint e, input bit wt);
    longint a, b, ce, pg;
    exp_t x;
    a = s; b = e;
    if (op == 0) begin
      if (a % LINE != 0) begin                     // R4 head line
        x.k = 2'd0; x.s = AW'(a - a % LINE); x.e = x.s; q.push_back(x);
        a = a - a % LINE + LINE;
      end
      if (a < b && b % LINE != 0) begin            // R5 tail line
        x.k = 2'd0; x.s = AW'(b - b % LINE); x.e = x.s; q.push_back(x);
        b = b - b % LINE;
      end
    end else begin                                 // R6 rounding
      a = a - a % LINE;
      b = ((b + LINE - 1) / LINE) * LINE;
    end
    if (op == 3 || (op == 1 && wt)) return;        // R8, R9
    while (a < b) begin
      ce = a + SPAN;                               // R2
      if (ce > b) ce = b;
      pg = (a / PAGE + 1) * PAGE;                  // R3
      if (ce > pg) ce = pg;
      if ((op == 1 || op == 2) && !wt) begin
        x.k = 2'd1; x.s = AW'(a); x.e = AW'(ce - LINE); q.push_back(x);
      end
      if (op == 0 || op == 2) begin                // R7 invalidate after clean
        x.k = 2'd2; x.s = AW'(a); x.e = AW'(ce - LINE); q.push_back(x);
      end
      a = ce;
    end
  endtask

  task automatic run_req(input string tag, input int op, input longint s,
                         input longint e, input bit wt, input bit stall);
    int n;
    cur_tag = tag;
    stall_mode = stall;
    expect_cmds(op, s, e, wt);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = 2'(op); req_start = AW'(s); req_end = AW'(e); wt_override = wt;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R10", "done pulse seen", longint'(done), 1);
    check(q.size() == 0, tag, "commands missing at done", q.size(), 0);
    q.delete();
    @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1, "R10", "done one cycle then idle",
          longint'(done), 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) @(negedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11", "req_ready after reset", longint'(req_ready), 1);
    check(cmd_valid == 1'b0, "R11", "cmd_valid after reset", longint'(cmd_valid), 0);
    check(done == 1'b0, "R11", "done after reset", longint'(done), 0);

    run_req("R1", 0, 64'h1000, 64'h1400, 1'b0, 1'b0);
    run_req("R4", 0, 64'h1004, 64'h1050, 1'b0, 1'b0);
    run_req("R5", 0, 64'h2004, 64'h2010, 1'b0, 1'b0);
    run_req("R5", 0, 64'h2000, 64'h2010, 1'b0, 1'b0);
    run_req("R3", 1, 64'h0F00, 64'h1A10, 1'b0, 1'b0);
    run_req("R6", 1, 64'h0F11, 64'h0F41, 1'b0, 1'b1);
    run_req("R7", 2, 64'h3010, 64'h3500, 1'b0, 1'b1);
    run_req("R8", 1, 64'h3000, 64'h3800, 1'b1, 1'b0);
    run_req("R8", 2, 64'h3F00, 64'h4A00, 1'b1, 1'b1);
    run_req("R9", 1, 64'h4000, 64'h4000, 1'b0, 1'b0);
    run_req("R9", 3, 64'h4000, 64'h5000, 1'b0, 1'b0);
    run_req("R2", 0, 64'h5008, 64'h7FF8, 1'b0, 1'b1);
    run_req("R2", 2, 64'h6E00, 64'h9000, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule